// File: doc/BRIEF.md
# Frequency Loss-of-Lock Detector

This block watches a clock recovery loop and raises a level alarm whenever the recovered clock is not running at the frequency of the reference. Both clocks reach it as single-cycle enable pulses in one system clock domain: one pulse per reference period, and one pulse per period of the recovered half-rate clock after it has been divided by 32. That division, and any other divider in the loop, is done outside this block.

Each measurement window is a fixed number of reference pulses, 2^WIN_LOG2. While the window is open, a second counter totals the recovered pulses. When the window closes, that total is compared with the nominal count 2^WIN_LOG2 plus or minus a tolerance TOL. The defaults are 8192 and 8, which gives about 1000 ppm. A total outside that band raises the alarm, and a total inside it clears the alarm. The alarm keeps its value until the next window closes. The next window begins on the following cycle with both counters at zero.

Top module: `lol_detector`

## Requirements
- R1: While rst_n is low, and from the first cycle after release until the end of the first complete window, lol_alarm is 1.
- R2: A window closes on the cycle that carries the 2^WIN_LOG2-th ref_tick since reset or since the last close. lol_alarm changes only on the clock edge of that cycle and holds its value at every other edge.
- R3: If the recovered total for a window lies between 2^WIN_LOG2-TOL and 2^WIN_LOG2+TOL, both bounds included, lol_alarm is 0 after the close.
- R4: If the recovered total exceeds 2^WIN_LOG2+TOL, lol_alarm is 1 after the close.
- R5: If the recovered total is below 2^WIN_LOG2-TOL, lol_alarm is 1 after the close.
- R6: If no rec_tick arrives during a window, lol_alarm is 1 after the close.
- R7: A rec_tick on the closing cycle counts toward the closing window. Both counters start from zero on the next cycle, so no pulse carries over from one window to the next.
- R8: The recovered counter saturates at its maximum value (WIN_LOG2+2 bits, all ones) and never wraps. A very fast recovered clock therefore always raises the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| rec_tick | input | 1 | One-cycle pulse per period of the recovered clock divided by 32 |
| lol_alarm | output | 1 | 1 while the loop is judged out of lock |

## Verification
Two situations are hard to reach from the ports. The first is a recovered total exactly on a tolerance bound with its last pulse on the closing cycle. The second is an overspeed total that would fold back into the lock band if the counter wrapped. The stimulus spreads an exact number of recovered pulses evenly over the cycles of a window, with reference pulses at a chosen spacing. The even spread puts a pulse on the final cycle for the bound cases. For the wrap case, a fivefold reference spacing gives a raw total of 1280, which would read as exactly nominal after a wrap. Stability of the alarm is checked on every cycle inside each window.

// File: rtl/lol_pkg.sv
// Package: types shared by the loss-of-lock detector modules.
// Assumes: nothing beyond a SystemVerilog-2017 tool.
package lol_pkg;

    // Outcome of comparing one window's recovered total against the band.
    typedef enum logic [1:0] {
        VERDICT_LOCK = 2'd0,
        VERDICT_SLOW = 2'd1,
        VERDICT_FAST = 2'd2
    } verdict_e;

endpackage

// File: rtl/lol_gate_timer.sv
// Module: lol_gate_timer
// Counts reference pulses and flags the cycle that closes a window of
// 2^WIN_LOG2 pulses. Assumes ref_tick is a single-cycle enable.
module lol_gate_timer #(
    parameter int WIN_LOG2 = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic win_end
);

    logic [WIN_LOG2-1:0] ref_cnt;

    // The window closes on the pulse that completes the count.
    assign win_end = ref_tick && (&ref_cnt);

    // Advance the reference count; it wraps to zero when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt <= '0;
        end else if (ref_tick) begin
            ref_cnt <= ref_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lol_tick_counter.sv
// Module: lol_tick_counter
// Saturating pulse counter with synchronous clear. cnt_next shows the count
// including the pulse of this cycle. Assumes clear takes priority over tick.
module lol_tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Add the current pulse unless the counter is already full.
    always_comb begin
        cnt_next = cnt_q;
        if (tick && (cnt_q != CNT_MAX)) begin
            cnt_next = cnt_q + 1'b1;
        end
    end

    // Hold the running total and clear it at the close of each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

endmodule

// File: rtl/lol_bound_check.sv
// Module: lol_bound_check
// Classifies a recovered total against the closed band [LO, HI].
// Purely combinational. Assumes LO <= HI and that both fit in CNT_W bits.
module lol_bound_check
    import lol_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int LO    = 8184,
    parameter int HI    = 8200
) (
    input  logic [CNT_W-1:0] total,
    output verdict_e         verdict
);

    localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO);
    localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI);

    // Pick the verdict from the two bound comparisons.
    always_comb begin
        if (total < LO_V) begin
            verdict = VERDICT_SLOW;
        end else if (total > HI_V) begin
            verdict = VERDICT_FAST;
        end else begin
            verdict = VERDICT_LOCK;
        end
    end

endmodule

// File: rtl/lol_detector.sv
// Module: lol_detector (top)
// Frequency loss-of-lock detector. It counts recovered pulses over a window
// of 2^WIN_LOG2 reference pulses and raises lol_alarm when the total is
// outside 2^WIN_LOG2 +/- TOL. Assumes both pulse inputs are synchronous to
// clk, at most one per cycle each, and TOL < 2^WIN_LOG2.
module lol_detector
    import lol_pkg::*;
#(
    parameter int WIN_LOG2 = 13,
    parameter int TOL      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic rec_tick,
    output logic lol_alarm
);

    localparam int CNT_W = WIN_LOG2 + 2;
    localparam int NOM   = 1 << WIN_LOG2;
    localparam int LO    = NOM - TOL;
    localparam int HI    = NOM + TOL;

    logic             win_end;
    logic [CNT_W-1:0] rec_cnt;
    logic [CNT_W-1:0] rec_total;
    verdict_e         verdict;

    lol_gate_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .win_end  (win_end)
    );

    lol_tick_counter #(.CNT_W(CNT_W)) u_rec_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (rec_tick),
        .clear    (win_end),
        .cnt_q    (rec_cnt),
        .cnt_next (rec_total)
    );

    lol_bound_check #(.CNT_W(CNT_W), .LO(LO), .HI(HI)) u_bounds (
        .total   (rec_total),
        .verdict (verdict)
    );

    // Hold the alarm; set it in reset and update it only when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol_alarm <= 1'b1;
        end else if (win_end) begin
            lol_alarm <= (verdict != VERDICT_LOCK);
        end
    end

endmodule

// File: rtl/lol_detector_chk.sv
// Module: lol_detector_chk
// Assertion checker bound into lol_detector. It watches the window close,
// the recovered counter and the alarm. Assumes the parameters of the host.
module lol_detector_chk #(
    parameter int CNT_W = 15,
    parameter int LO    = 8184,
    parameter int HI    = 8200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_tick,
    input logic             win_end,
    input logic [CNT_W-1:0] rec_cnt,
    input logic             lol_alarm
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W:0] raw_total;
    assign raw_total = {1'b0, rec_cnt} + (CNT_W+1)'(rec_tick);

    assert_reset_alarm_R1: assert property (@(posedge clk)
        !rst_n |=> lol_alarm);

    assert_alarm_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(lol_alarm));

    assert_lock_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && raw_total >= (CNT_W+1)'(LO) && raw_total <= (CNT_W+1)'(HI)) |=> !lol_alarm);

    assert_fast_alarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && raw_total > (CNT_W+1)'(HI)) |=> lol_alarm);

    assert_slow_alarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && raw_total < (CNT_W+1)'(LO)) |=> lol_alarm);

    assert_missing_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && rec_cnt == '0 && !rec_tick) |=> lol_alarm);

    assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (rec_cnt == '0));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_cnt == CNT_MAX && !win_end) |=> (rec_cnt == CNT_MAX));

endmodule

bind lol_detector lol_detector_chk #(.CNT_W(CNT_W), .LO(LO), .HI(HI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_tick  (rec_tick),
    .win_end   (win_end),
    .rec_cnt   (rec_cnt),
    .lol_alarm (lol_alarm)
);

// File: tb/lol_detector_test.sv
`timescale 1ns/1ps
module lol_detector_test;

    localparam int WIN_LOG2 = 8;
    localparam int TOL      = 4;
    localparam int NOM      = 1 << WIN_LOG2;

    // Each vector: reference spacing in cycles, recovered pulses, expected alarm.
    localparam int NVEC = 11;
    localparam int VEC [NVEC][3] = '{
        '{2, 256, 0},   // R3 nominal
        '{2, 260, 0},   // R3 upper bound, last pulse on the closing cycle (R7)
        '{2, 252, 0},   // R3 lower bound
        '{2, 261, 1},   // R4 one above the band
        '{2, 256, 0},   // R3 relock
        '{2, 251, 1},   // R5 one below the band
        '{3, 256, 0},   // R3 other reference spacing
        '{2, 0,   1},   // R6 missing recovered clock
        '{3, 600, 1},   // R4 far too fast
        '{5, 1280, 1},  // R8 saturation; a wrap would read 256
        '{2, 256, 0}    // R7 clean restart after saturation
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic rec_tick = 1'b0;
    logic lol_alarm;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lol_detector #(.WIN_LOG2(WIN_LOG2), .TOL(TOL)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .rec_tick  (rec_tick),
        .lol_alarm (lol_alarm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One full window; pulses spread evenly. Checks hold (R2) and the result.
    task automatic run_window(input int per, input int k, input int exp, input string req);
        int total = per * NOM;
        int held = 1;
        logic first = 1'b0;
        for (int c = 0; c < total; c++) begin
            @(negedge clk);
            if (c == 0) first = lol_alarm;
            else if (lol_alarm !== first) held = 0;
            ref_tick = ((c % per) == per - 1);
            rec_tick = (((c * k) / total) != (((c + 1) * k) / total));
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        check(held == 1, "R2", held, 1);
        check(lol_alarm === exp[0], req, lol_alarm, exp);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(lol_alarm === 1'b1, "R1", lol_alarm, 1);
        rst_n = 1'b1;
        // First window: alarm held high throughout (R1) then clears (R3).
        run_window(2, 256, 0, "R1");

        for (int i = 0; i < NVEC; i++) begin
            string req;
            case (i)
                3, 8:    req = "R4";
                5:       req = "R5";
                7:       req = "R6";
                9:       req = "R8";
                10:      req = "R7";
                default: req = "R3";
            endcase
            run_window(VEC[i][0], VEC[i][1], VEC[i][2], req);
        end

        // R1: reset in the middle of a window forces the alarm and restarts.
        for (int c = 0; c < NOM; c++) begin
            @(negedge clk);
            ref_tick = (c % 2 == 1);
            rec_tick = 1'b1;
        end
        @(negedge clk);
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check(lol_alarm === 1'b1, "R1", lol_alarm, 1);
        rst_n = 1'b1;
        run_window(2, 258, 0, "R1");

        // R7: a pulse right after a close belongs to the next window only.
        run_window(2, 261, 1, "R4");
        run_window(2, 256, 0, "R7");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule